// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block carries out the entry into an interrupt handler for a processor running in its flat, real-address style mode. A one-cycle start pulse hands it a vector number, the current 32-bit flags word, the current code segment and 16-bit instruction pointer, the limit of the interrupt table and the stack pointer. The block captures these values and checks two things. First, the whole 4-byte table entry must lie inside the table limit. Second, the stack must have room for six bytes of return information.

When both checks pass, the block writes three 16-bit words down the stack: the low half of the flags, then the code segment, then the instruction pointer. It then clears the interrupt-enable, trap and alignment-check flags. Next it issues one read of the 32-bit table entry at vector times four and waits for the read data to come back. The entry supplies the new code segment and the new instruction pointer, and the sequence ends with a one-cycle done pulse. When a check fails, a one-cycle fault pulse reports a code for the fault type, and nothing else changes.

The surrounding core takes the new code pointer, flags and stack pointer from the result outputs when it sees done. On fault it keeps its own state and raises the matching exception.

Top module: `rm_irq_entry`

## Requirements
- R1: After the three pushes the block issues exactly one table read, with `tb_addr_o` equal to vector*4. It loads `new_cs_o` from read data bits [31:16] and the offset from bits [15:0].
- R2: If vector*4+3 is greater than the table limit, `fault_o` pulses for one cycle with `fault_code_o` = 1 (general protection). There are no stack writes and no table read, and `new_cs_o`, `new_ip_o`, `new_sp_o` and `new_flags_o` keep their previous values. This check takes precedence over the stack check.
- R3: If the limit check passes and the stack pointer is below 6, `fault_o` pulses for one cycle with `fault_code_o` = 2 (stack fault). There are no stack writes and no table read, and the result outputs keep their previous values.
- R4: On a good entry the block makes exactly three stack writes in consecutive cycles, with no error code. The writes go to SP-2 with flags[15:0], then to SP-4 with CS, then to SP-6 with IP. `new_sp_o` becomes SP-6.
- R5: `new_flags_o` equals the input flags with bits 8 (trap), 9 (interrupt enable) and 18 (alignment check) cleared, and every other bit kept. The word pushed to the stack still carries the uncleared bits 8 and 9.
- R6: `new_ip_o` is 32 bits wide: the 16-bit table offset, zero-extended.
- R7: The block waits in its fetch step for `tb_rvalid_i`, for any number of cycles. `done_o` rises in the cycle after the edge at which valid is sampled.
- R8: Each accepted start ends with exactly one pulse, either `done_o` or `fault_o`, never both. `fault_code_o` reads 0 after a done.
- R9: A start pulse that arrives while a sequence is running is ignored. The running sequence keeps the inputs it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin an entry sequence |
| vector_i | input | 8 | Interrupt vector number |
| flags_i | input | 32 | Current flags word |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| sp_i | input | 16 | Current stack pointer |
| limit_i | input | 16 | Interrupt table limit (last valid byte offset) |
| st_we_o | output | 1 | Stack write strobe |
| st_addr_o | output | 16 | Stack write byte address |
| st_wdata_o | output | 16 | Stack write data |
| tb_re_o | output | 1 | Table read request, one cycle |
| tb_addr_o | output | 16 | Table read byte address |
| tb_rvalid_i | input | 1 | Table read data valid |
| tb_rdata_i | input | 32 | Table entry: [31:16] segment, [15:0] offset |
| done_o | output | 1 | Sequence completed pulse |
| fault_o | output | 1 | Sequence aborted pulse |
| fault_code_o | output | 2 | 0 none, 1 general protection, 2 stack fault |
| new_cs_o | output | 16 | Loaded code segment |
| new_ip_o | output | 32 | Loaded instruction pointer |
| new_sp_o | output | 16 | Stack pointer after the pushes |
| new_flags_o | output | 32 | Flags with the three control bits cleared |

## Verification
The in-RTL properties check the following on every cycle:
- consecutive stack writes step down by two bytes;
- a fault pulse never follows a stack write, and the read request only comes after three writes;
- done and fault never coincide, and done only comes one cycle after a valid sample;
- the fetch step holds while valid is low.

The vector bench scenarios cover what needs specific values:
- the exact boundary of the table limit;
- the stack pointer at exactly 6 and at 5;
- the precedence of the limit fault;
- the data and order of each pushed word;
- the split of the entry into segment and offset;
- the result outputs held unchanged across a fault;
- a start pulse ignored while a sequence is running.

// File: rtl/rm_irq_pkg.sv
package rm_irq_pkg;

  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_CHECK      = 3'd1,
    S_PUSH_FLAGS = 3'd2,
    S_PUSH_CS    = 3'd3,
    S_PUSH_IP    = 3'd4,
    S_FETCH      = 3'd5,
    S_DONE       = 3'd6
  } seq_state_e;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_GP   = 2'd1;
  localparam logic [1:0] FLT_SS   = 2'd2;

  localparam int unsigned WORD_W      = 16;
  localparam int unsigned ENTRY_BYTES = 4;
  localparam int unsigned RET_BYTES   = 6;
  localparam int unsigned WORD_BYTES  = 2;

  localparam int unsigned BIT_TF = 8;
  localparam int unsigned BIT_IF = 9;
  localparam int unsigned BIT_AC = 18;

endpackage

// File: rtl/rm_irq_guard.sv
module rm_irq_guard
  import rm_irq_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned LIM_W  = 16,
  parameter int unsigned SP_W   = 16,
  parameter int unsigned TBL_AW = 16
) (
  input  logic [VEC_W-1:0]  vector_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic [TBL_AW-1:0] entry_addr_o,
  output logic              limit_bad_o,
  output logic              stack_bad_o
);

  localparam int unsigned SPAN_W = VEC_W + 2;
  localparam int unsigned CMP_W  = ((SPAN_W > LIM_W) ? SPAN_W : LIM_W) + 1;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] lim_ext;

  always_comb begin
    last_byte    = (CMP_W'(vector_i) << 2) | CMP_W'(ENTRY_BYTES - 1);
    lim_ext      = CMP_W'(limit_i);
    limit_bad_o  = (last_byte > lim_ext);
    stack_bad_o  = (sp_i < SP_W'(RET_BYTES));
    entry_addr_o = TBL_AW'(vector_i) << 2;
  end

endmodule

// File: rtl/rm_irq_flagmask.sv
module rm_irq_flagmask
  import rm_irq_pkg::*;
#(
  parameter int unsigned FLAG_W = 32
) (
  input  logic [FLAG_W-1:0] flags_i,
  output logic [WORD_W-1:0] push_word_o,
  output logic [FLAG_W-1:0] cleared_o
);

  assign push_word_o = flags_i[WORD_W-1:0];

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (b == BIT_TF || b == BIT_IF || b == BIT_AC) begin : g_clr
      assign cleared_o[b] = 1'b0;
    end else begin : g_keep
      assign cleared_o[b] = flags_i[b];
    end
  end

endmodule

// File: rtl/rm_irq_fsm.sv
module rm_irq_fsm
  import rm_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       limit_bad_i,
  input  logic       stack_bad_i,
  input  logic       rvalid_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       fault_go_o,
  output logic       req_o,
  output logic       take_o
);

  seq_state_e state_q, state_d;
  logic       req_sent_q, req_sent_d;

  always_comb begin
    state_d    = state_q;
    req_sent_d = req_sent_q;
    accept_o   = 1'b0;
    fault_go_o = 1'b0;
    take_o     = 1'b0;
    req_o      = (state_q == S_FETCH) && !req_sent_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = S_CHECK;
        end
      end
      S_CHECK: begin
        if (limit_bad_i || stack_bad_i) begin
          fault_go_o = 1'b1;
          state_d    = S_IDLE;
        end else begin
          state_d = S_PUSH_FLAGS;
        end
      end
      S_PUSH_FLAGS: state_d = S_PUSH_CS;
      S_PUSH_CS:    state_d = S_PUSH_IP;
      S_PUSH_IP: begin
        state_d    = S_FETCH;
        req_sent_d = 1'b0;
      end
      S_FETCH: begin
        if (!req_sent_q) begin
          req_sent_d = 1'b1;
        end else if (rvalid_i) begin
          take_o  = 1'b1;
          state_d = S_DONE;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      req_sent_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      req_sent_q <= req_sent_d;
    end
  end

  assign state_o = state_q;

  // R7: with the request out and no valid, the fetch step holds
  p_hold_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH && req_sent_q && !rvalid_i) |=> (state_q == S_FETCH));

  // R2/R3: a failed check returns to idle without touching the push steps
  p_fault_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CHECK && (limit_bad_i || stack_bad_i)) |=> (state_q == S_IDLE));

endmodule

// File: rtl/rm_irq_entry.sv
module rm_irq_entry
  import rm_irq_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned FLAG_W = 32,
  parameter int unsigned SP_W   = 16,
  parameter int unsigned LIM_W  = 16,
  parameter int unsigned TBL_AW = 16,
  parameter int unsigned IP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  vector_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [15:0]       cs_i,
  input  logic [15:0]       ip_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [LIM_W-1:0]  limit_i,
  output logic              st_we_o,
  output logic [SP_W-1:0]   st_addr_o,
  output logic [15:0]       st_wdata_o,
  output logic              tb_re_o,
  output logic [TBL_AW-1:0] tb_addr_o,
  input  logic              tb_rvalid_i,
  input  logic [31:0]       tb_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic [15:0]       new_cs_o,
  output logic [IP_W-1:0]   new_ip_o,
  output logic [SP_W-1:0]   new_sp_o,
  output logic [FLAG_W-1:0] new_flags_o
);

  localparam logic [SP_W-1:0] SP_STEP = SP_W'(WORD_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // captured operands and working registers
  logic [VEC_W-1:0]  vec_q;
  logic [LIM_W-1:0]  lim_q;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [15:0]       cs_q, ip_q;
  logic              sp_en, flags_en;

  // result registers
  logic [15:0]       rcs_q, rcs_d;
  logic [IP_W-1:0]   rip_q, rip_d;
  logic [SP_W-1:0]   rsp_q;
  logic [FLAG_W-1:0] rflags_q;
  logic              fault_q, fault_d;
  logic [1:0]        code_q, code_d;
  logic              code_en;

  seq_state_e        state;
  logic              accept, fault_go, take;
  logic              limit_bad, stack_bad;
  logic [TBL_AW-1:0] entry_addr;
  logic [15:0]       flags_word;
  logic [FLAG_W-1:0] flags_clr;

  rm_irq_guard #(
    .VEC_W (VEC_W),
    .LIM_W (LIM_W),
    .SP_W  (SP_W),
    .TBL_AW(TBL_AW)
  ) u_guard (
    .vector_i    (vec_q),
    .limit_i     (lim_q),
    .sp_i        (sp_q),
    .entry_addr_o(entry_addr),
    .limit_bad_o (limit_bad),
    .stack_bad_o (stack_bad)
  );

  rm_irq_flagmask #(
    .FLAG_W(FLAG_W)
  ) u_flagmask (
    .flags_i    (flags_q),
    .push_word_o(flags_word),
    .cleared_o  (flags_clr)
  );

  rm_irq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .limit_bad_i(limit_bad),
    .stack_bad_i(stack_bad),
    .rvalid_i   (tb_rvalid_i),
    .state_o    (state),
    .accept_o   (accept),
    .fault_go_o (fault_go),
    .req_o      (tb_re_o),
    .take_o     (take)
  );

  // next-state for the datapath
  always_comb begin
    sp_en    = 1'b0;
    sp_d     = sp_q;
    flags_en = 1'b0;
    flags_d  = flags_q;
    code_en  = 1'b0;
    code_d   = code_q;
    fault_d  = fault_go;
    rcs_d    = tb_rdata_i[31:16];
    rip_d    = IP_W'(tb_rdata_i[15:0]);
    if (accept) begin
      sp_en    = 1'b1;
      sp_d     = sp_i;
      flags_en = 1'b1;
      flags_d  = flags_i;
      code_en  = 1'b1;
      code_d   = FLT_NONE;
    end else begin
      if (fault_go) begin
        code_en = 1'b1;
        code_d  = limit_bad ? FLT_GP : FLT_SS;
      end
      if (st_we_o) begin
        sp_en = 1'b1;
        sp_d  = sp_q - SP_STEP;
      end
      if (state == S_PUSH_FLAGS) begin
        flags_en = 1'b1;
        flags_d  = flags_clr;
      end
    end
  end

  // stack write port
  always_comb begin
    st_we_o    = (state == S_PUSH_FLAGS) || (state == S_PUSH_CS) || (state == S_PUSH_IP);
    st_addr_o  = sp_q - SP_STEP;
    unique case (state)
      S_PUSH_FLAGS: st_wdata_o = flags_word;
      S_PUSH_CS:    st_wdata_o = cs_q;
      default:      st_wdata_o = ip_q;
    endcase
  end

  assign tb_addr_o = entry_addr;

  // register processes
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q <= '0;
      lim_q <= '0;
      cs_q  <= '0;
      ip_q  <= '0;
    end else if (accept) begin
      vec_q <= vector_i;
      lim_q <= limit_i;
      cs_q  <= cs_i;
      ip_q  <= ip_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rcs_q    <= '0;
      rip_q    <= '0;
      rsp_q    <= '0;
      rflags_q <= '0;
    end else if (take) begin
      rcs_q    <= rcs_d;
      rip_q    <= rip_d;
      rsp_q    <= sp_q;
      rflags_q <= flags_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fault_q <= 1'b0;
      code_q  <= FLT_NONE;
    end else begin
      fault_q <= fault_d;
      if (code_en) begin
        code_q <= code_d;
      end
    end
  end

  assign done_o       = (state == S_DONE);
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign new_cs_o     = rcs_q;
  assign new_ip_o     = rip_q;
  assign new_sp_o     = rsp_q;
  assign new_flags_o  = rflags_q;

  // ---------------- checks ----------------
  logic [1:0] wr_cnt_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_cnt_q <= 2'd0;
    end else if (accept) begin
      wr_cnt_q <= 2'd0;
    end else if (st_we_o) begin
      wr_cnt_q <= wr_cnt_q + 2'd1;
    end
  end

  // R4: back-to-back pushes walk down by one word
  p_push_descend_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_we_o && $past(st_we_o)) |-> (st_addr_o == $past(st_addr_o) - SP_STEP));

  // R4: completion only after exactly three pushes
  p_three_pushes_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (wr_cnt_q == 2'd3));

  // R2/R3: a fault is reported before any stack write
  p_fault_no_push_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_o |-> (wr_cnt_q == 2'd0));

  // R1: the table read follows the three pushes
  p_read_after_push_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tb_re_o |-> (wr_cnt_q == 2'd3));

  // R8: one ending per sequence
  p_single_end_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(done_o && fault_o));

  // R7: done only after valid was sampled
  p_done_after_valid_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> $past(tb_rvalid_i));

  // R5: control flags are clear in the result
  p_flags_clear_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (!new_flags_o[BIT_IF] && !new_flags_o[BIT_TF] && !new_flags_o[BIT_AC]));

endmodule

// File: tb/tb_rm_irq_entry.sv
`timescale 1ns/1ps
module tb_rm_irq_entry;

  localparam real CLK_PER = 8.0;

  typedef struct packed {
    logic [7:0]  vec;
    logic [15:0] lim;
    logic [15:0] sp;
    logic [31:0] flags;
    logic [15:0] cs;
    logic [15:0] ip;
    logic [31:0] entry;
    logic [3:0]  dly;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h08, 16'h03FF, 16'h1000, 32'h0004_0302, 16'h1234, 16'h5678, 32'hF000_E987, 4'd0},
    '{8'h21, 16'h0087, 16'h0006, 32'hFFFF_FFFF, 16'hAAAA, 16'h5555, 32'h0040_0010, 4'd3},
    '{8'h21, 16'h0086, 16'h2000, 32'h0000_0200, 16'h0101, 16'h0202, 32'h1357_2468, 4'd0},
    '{8'h05, 16'h03FF, 16'h0005, 32'h0000_0300, 16'h0303, 16'h0404, 32'h9999_8888, 4'd0},
    '{8'hFF, 16'h0010, 16'h0002, 32'h0004_0000, 16'h0505, 16'h0606, 32'h7777_6666, 4'd0},
    '{8'hFF, 16'hFFFF, 16'hFFFE, 32'h0000_0000, 16'h0000, 16'hFFFF, 32'hFFFF_FFFF, 4'd1},
    '{8'h00, 16'h0003, 16'h0100, 32'h0000_0200, 16'hBEEF, 16'hCAFE, 32'h1111_2222, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  vector_i;
  logic [31:0] flags_i;
  logic [15:0] cs_i, ip_i, sp_i, limit_i;
  logic        st_we_o;
  logic [15:0] st_addr_o, st_wdata_o;
  logic        tb_re_o;
  logic [15:0] tb_addr_o;
  logic        tb_rvalid_i;
  logic [31:0] tb_rdata_i;
  logic        done_o, fault_o;
  logic [1:0]  fault_code_o;
  logic [15:0] new_cs_o;
  logic [31:0] new_ip_o;
  logic [15:0] new_sp_o;
  logic [31:0] new_flags_o;

  always #(CLK_PER/2) clk = ~clk;

  rm_irq_entry dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vector_i(vector_i),
    .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i), .sp_i(sp_i), .limit_i(limit_i),
    .st_we_o(st_we_o), .st_addr_o(st_addr_o), .st_wdata_o(st_wdata_o),
    .tb_re_o(tb_re_o), .tb_addr_o(tb_addr_o), .tb_rvalid_i(tb_rvalid_i),
    .tb_rdata_i(tb_rdata_i), .done_o(done_o), .fault_o(fault_o),
    .fault_code_o(fault_code_o), .new_cs_o(new_cs_o), .new_ip_o(new_ip_o),
    .new_sp_o(new_sp_o), .new_flags_o(new_flags_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // observation and table memory model (negedge side)
  int          wr_n, re_n, done_n, fault_n;
  logic [15:0] wr_addr [8];
  logic [15:0] wr_data [8];
  logic [15:0] re_addr;
  logic [31:0] mem_word;
  int          mem_dly;
  bit          mem_pend;
  int          mem_cnt;

  initial begin
    tb_rvalid_i = 1'b0;
    tb_rdata_i  = '0;
    mem_pend    = 1'b0;
    mem_cnt     = 0;
  end

  always @(negedge clk) begin
    if (st_we_o) begin
      if (wr_n < 8) begin
        wr_addr[wr_n] = st_addr_o;
        wr_data[wr_n] = st_wdata_o;
      end
      wr_n++;
    end
    if (tb_re_o) begin
      re_n++;
      re_addr = tb_addr_o;
    end
    if (done_o)  done_n++;
    if (fault_o) fault_n++;
    tb_rvalid_i = 1'b0;
    if (mem_pend) begin
      if (mem_cnt == 0) begin
        tb_rvalid_i = 1'b1;
        tb_rdata_i  = mem_word;
        mem_pend    = 1'b0;
      end else begin
        mem_cnt--;
      end
    end
    if (tb_re_o) begin
      mem_pend = 1'b1;
      mem_cnt  = mem_dly;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    logic [1:0]  ef;
    logic [15:0] pcs, psp;
    logic [31:0] pip, pfl, ecl;
    bit          hit;
    ef  = (({8'h00, v.vec} << 2) + 18'd3 > {2'b00, v.lim}) ? 2'd1 :
          (v.sp < 16'd6) ? 2'd2 : 2'd0;
    ecl = v.flags & ~(32'h1 << 8) & ~(32'h1 << 9) & ~(32'h1 << 18);
    @(negedge clk);
    pcs = new_cs_o; pip = new_ip_o; psp = new_sp_o; pfl = new_flags_o;
    wr_n = 0; re_n = 0; done_n = 0; fault_n = 0;
    mem_word = v.entry; mem_dly = int'(v.dly);
    vector_i = v.vec; limit_i = v.lim; sp_i = v.sp; flags_i = v.flags;
    cs_i = v.cs; ip_i = v.ip; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      vector_i = v.vec ^ 8'h01; sp_i = v.sp ^ 16'h0F00; cs_i = ~v.cs; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    hit = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(posedge clk);
      if (done_n + fault_n > 0) begin
        hit = 1'b1;
        break;
      end
    end
    repeat (6) @(negedge clk);
    chk(hit, "R8", "sequence ended (watchdog)", 32'(hit), 32'd1);
    chk(fault_code_o == ef, (ef == 2'd1) ? "R2" : (ef == 2'd2) ? "R3" : "R8",
        "fault code", 32'(fault_code_o), 32'(ef));
    chk(done_n == ((ef == 0) ? 1 : 0), "R8", "done pulses", 32'(done_n), (ef == 0) ? 32'd1 : 32'd0);
    chk(fault_n == ((ef != 0) ? 1 : 0), "R8", "fault pulses", 32'(fault_n), (ef != 0) ? 32'd1 : 32'd0);
    if (ef != 2'd0) begin
      chk(wr_n == 0, "R2", "no stack writes on fault", 32'(wr_n), 32'd0);
      chk(re_n == 0, "R3", "no table read on fault", 32'(re_n), 32'd0);
      chk(new_cs_o == pcs, "R2", "cs unchanged", 32'(new_cs_o), 32'(pcs));
      chk(new_ip_o == pip, "R2", "ip unchanged", new_ip_o, pip);
      chk(new_sp_o == psp, "R3", "sp unchanged", 32'(new_sp_o), 32'(psp));
      chk(new_flags_o == pfl, "R3", "flags unchanged", new_flags_o, pfl);
    end else begin
      chk(wr_n == 3, "R4", "push count", 32'(wr_n), 32'd3);
      chk(wr_addr[0] == v.sp - 16'd2, "R4", "flags push addr", 32'(wr_addr[0]), 32'(v.sp - 16'd2));
      chk(wr_data[0] == v.flags[15:0], "R5", "flags push data", 32'(wr_data[0]), 32'(v.flags[15:0]));
      chk(wr_addr[1] == v.sp - 16'd4, "R4", "cs push addr", 32'(wr_addr[1]), 32'(v.sp - 16'd4));
      chk(wr_data[1] == v.cs, "R9", "cs push data", 32'(wr_data[1]), 32'(v.cs));
      chk(wr_addr[2] == v.sp - 16'd6, "R4", "ip push addr", 32'(wr_addr[2]), 32'(v.sp - 16'd6));
      chk(wr_data[2] == v.ip, "R4", "ip push data", 32'(wr_data[2]), 32'(v.ip));
      chk(re_n == 1, "R1", "table reads", 32'(re_n), 32'd1);
      chk(re_addr == {6'd0, v.vec, 2'b00}, "R1", "table addr", 32'(re_addr), 32'({v.vec, 2'b00}));
      chk(new_cs_o == v.entry[31:16], "R1", "new cs", 32'(new_cs_o), 32'(v.entry[31:16]));
      chk(new_ip_o == {16'h0, v.entry[15:0]}, "R6", "new ip", new_ip_o, {16'h0, v.entry[15:0]});
      chk(new_sp_o == v.sp - 16'd6, "R4", "new sp", 32'(new_sp_o), 32'(v.sp - 16'd6));
      chk(new_flags_o == ecl, "R5", "new flags", new_flags_o, ecl);
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; vector_i = '0; flags_i = '0;
    cs_i = '0; ip_i = '0; sp_i = '0; limit_i = '0;
    wr_n = 0; re_n = 0; done_n = 0; fault_n = 0; mem_word = '0; mem_dly = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk(!done_o && !fault_o, "R8", "no pulse after reset", {30'd0, done_o, fault_o}, 32'd0);
    chk(!st_we_o && !tb_re_o, "R4", "ports quiet after reset", {30'd0, st_we_o, tb_re_o}, 32'd0);
    chk(fault_code_o == 2'd0 && new_sp_o == 16'd0, "R3", "result regs after reset",
        {14'd0, fault_code_o, new_sp_o}, 32'd0);
    // vector table
    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);
    // R9: start while busy is ignored (delayed valid widens the window)
    run_vec('{8'h10, 16'h03FF, 16'h0800, 32'h0004_0100, 16'h4321, 16'h8765, 32'h2222_3333, 4'd4}, 1'b1);
    // R7: long valid delay, then a fault right after a good entry keeps results
    run_vec('{8'h40, 16'h03FF, 16'h0010, 32'h0000_FFFF, 16'h0A0A, 16'h0B0B, 32'hABCD_0123, 4'd15}, 1'b0);
    run_vec('{8'h40, 16'h00FF, 16'h0010, 32'h0000_0000, 16'h0000, 16'h0000, 32'h0, 4'd0}, 1'b0);
    summary();
  end

  initial begin
    #(CLK_PER * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule